// File: doc/BRIEF.md
# Cache Event Counter Unit

This unit counts cache activity for a level-2 cache controller. It holds two identical 32-bit counters. Each counter listens to one of fifteen single-cycle event strobes from the cache. A 4-bit source code picks the strobe, and code zero turns the counter off. When a counter reaches all-ones it stays there instead of rolling over. Software that samples the counters at regular intervals can therefore tell that a count was lost, because the counter is pinned at its largest value.

Software reaches the unit through a small register port. A single write or read takes one cycle, and read data comes back one cycle later. The port gives access to a global control register whose bit 0 starts and stops all counting. Each counter also has a configuration register and a value register. The per-counter registers are placed in descending order, so counter 1 sits one word below counter 0. Software can write a value register at any time to clear a counter or preload it. An interrupt output can signal saturation or counted events for each counter, and it stays low for any counter whose interrupt mode is off.

Top module: `cache_evt_ctr`

## Requirements
- R1: After reset the control register, both configuration registers and both value registers read as zero, and `irq` is low.
- R2: A counter that holds 0xFFFFFFFF stays at that value when further selected events arrive, and it never wraps to zero on its own.
- R3: Counting happens only while bit 0 of the control register at byte address 0x00 is 1. While that bit is 0, both counters hold their values whatever events arrive.
- R4: A source code c between 1 and 15 makes the counter count pulses on `evt_in[c-1]` and ignore every other event bit. Code 0 makes the counter ignore all events.
- R5: The configuration registers sit at 0x08 (counter 0) and 0x04 (counter 1), and the value registers at 0x10 (counter 0) and 0x0C (counter 1). In a configuration register, bits [5:2] hold the source code and bits [1:0] hold the interrupt mode. Both fields read back as written, and all other bits read as zero.
- R6: A read request returns its data on `reg_rdata` in the next cycle. The data shows the register contents as they stood in the cycle of the request.
- R7: When a value-register write and a counted event fall in the same cycle, the counter takes the written value and the event is dropped.
- R8: Interrupt mode 00 keeps that counter's share of `irq` low. Mode 01 raises `irq` while the counter holds all-ones. Mode 10 raises `irq` for one cycle after each cycle in which the counter incremented. Mode 11 combines modes 01 and 10.
- R9: A counter advances by exactly one for each cycle in which its selected event bit is high and counting is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_sel | input | 1 | Register access request for this cycle |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 5 | Byte address of the register |
| reg_wdata | input | 32 | Write data |
| evt_in | input | 15 | Cache event strobes; bit c-1 belongs to source code c |
| reg_rdata | output | 32 | Read data, one cycle after the request |
| irq | output | 1 | Interrupt, the OR of the enabled per-counter conditions |

## Verification
Two pairs of functions can fall in the same cycle. A software write to a value register can coincide with a counted event, and a read of a counter can coincide with its increment. The bench provokes both by driving the register access and the selected event strobe on the same falling edge. It then judges the result at the port: after the collision the written value must read back untouched, and the read data must show the count from before the increment while a later read shows the increment.

// File: rtl/cevt_pkg.sv
package cevt_pkg;

    localparam int CNT_W   = 32;
    localparam int DATA_W  = 32;
    localparam int NUM_CTR = 2;
    localparam int SRC_W   = 4;
    localparam int NUM_EVT = (1 << SRC_W) - 1;

    typedef enum logic [1:0] {
        IRQ_OFF  = 2'b00,
        IRQ_SAT  = 2'b01,
        IRQ_STEP = 2'b10,
        IRQ_BOTH = 2'b11
    } irq_mode_e;

    // Field order sets the bit positions: source in [5:2], mode in [1:0]
    typedef struct packed {
        logic [SRC_W-1:0] src;
        irq_mode_e        mode;
    } ctr_cfg_t;

    localparam int CFG_W = $bits(ctr_cfg_t);

    function automatic logic irq_fire(input irq_mode_e mode, input logic sat,
                                      input logic stepped);
        logic r;
        case (mode)
            IRQ_SAT:  r = sat;
            IRQ_STEP: r = stepped;
            IRQ_BOTH: r = sat | stepped;
            default:  r = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/cevt_src_sel.sv
module cevt_src_sel #(
    parameter int SRC_W   = 4,
    parameter int NUM_EVT = (1 << SRC_W) - 1
) (
    input  logic [NUM_EVT-1:0] evt_in,
    input  logic [SRC_W-1:0]   src,
    output logic               hit
);
    localparam int EXT_W = NUM_EVT + 1;

    // Slot 0 is tied low, so source code 0 never selects an event
    logic [EXT_W-1:0] ext;
    assign ext = {evt_in, 1'b0};
    assign hit = ext[src];

endmodule

// File: rtl/cevt_sat_counter.sv
module cevt_sat_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             hit,
    input  logic             src_on,
    input  logic             wr,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] cnt,
    output logic             sat,
    output logic             stepped
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic step;
    logic past_ok;

    assign sat  = &cnt;
    assign step = run & hit & ~sat;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            stepped <= 1'b0;
            past_ok <= 1'b0;
        end else begin
            past_ok <= 1'b1;
            if (wr) begin
                cnt     <= wdata;
                stepped <= 1'b0;
            end else if (step) begin
                cnt     <= cnt + ONE;
                stepped <= 1'b1;
            end else begin
                stepped <= 1'b0;
            end
        end
    end

    AST_SAT_STICKS: assert property (@(posedge clk) disable iff (rst)
        (past_ok && sat && !wr) |=> sat); // R2
    AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
        (past_ok && !wr) |=> (cnt == $past(cnt) || cnt == $past(cnt) + ONE)); // R9
    AST_FROZEN_OFF: assert property (@(posedge clk) disable iff (rst)
        (past_ok && !run && !wr) |=> $stable(cnt)); // R3
    AST_SRC_OFF: assert property (@(posedge clk) disable iff (rst)
        (past_ok && !src_on && !wr) |=> $stable(cnt)); // R4
    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (rst)
        (past_ok && wr) |=> (cnt == $past(wdata))); // R7

endmodule

// File: rtl/cache_evt_ctr.sv
module cache_evt_ctr
    import cevt_pkg::*;
#(
    parameter int NUM_C = NUM_CTR,
    parameter int CW    = CNT_W,
    parameter int DW    = DATA_W,
    parameter int SW    = SRC_W,
    parameter int NE    = (1 << SW) - 1,
    parameter int AW    = $clog2(8 * NUM_C + 4)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          reg_sel,
    input  logic          reg_wr,
    input  logic [AW-1:0] reg_addr,
    input  logic [DW-1:0] reg_wdata,
    input  logic [NE-1:0] evt_in,
    output logic [DW-1:0] reg_rdata,
    output logic          irq
);
    localparam logic [AW-1:0] A_CTRL = '0;

    // Descending layout: counter i sits 4*i bytes below counter 0
    function automatic logic [AW-1:0] cfg_addr(input int i);
        return AW'(4 * (NUM_C - i));
    endfunction

    function automatic logic [AW-1:0] val_addr(input int i);
        return AW'(4 * (2 * NUM_C - i));
    endfunction

    logic             en_q;
    ctr_cfg_t         cfg_q   [NUM_C];
    logic [CW-1:0]    cnt_arr [NUM_C];
    logic [NUM_C-1:0] sat_v;
    logic [NUM_C-1:0] step_v;
    logic [NUM_C-1:0] irq_v;
    logic [NUM_C-1:0] mode_on;
    logic [DW-1:0]    rd_mux;
    logic             wr_go;
    logic             rd_go;

    assign wr_go = reg_sel & reg_wr;
    assign rd_go = reg_sel & ~reg_wr;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q <= 1'b0;
        end else if (wr_go && reg_addr == A_CTRL) begin
            en_q <= reg_wdata[0];
        end
    end

    for (genvar i = 0; i < NUM_C; i++) begin : g_ctr
        logic wr_cfg;
        logic wr_val;
        logic hit;

        assign wr_cfg = wr_go && reg_addr == cfg_addr(i);
        assign wr_val = wr_go && reg_addr == val_addr(i);

        always_ff @(posedge clk) begin
            if (rst) begin
                cfg_q[i] <= '{src: '0, mode: IRQ_OFF};
            end else if (wr_cfg) begin
                cfg_q[i] <= ctr_cfg_t'(reg_wdata[CFG_W-1:0]);
            end
        end

        cevt_src_sel #(.SRC_W(SW), .NUM_EVT(NE)) u_sel (
            .evt_in (evt_in),
            .src    (cfg_q[i].src),
            .hit    (hit)
        );

        cevt_sat_counter #(.CNT_W(CW)) u_cnt (
            .clk     (clk),
            .rst     (rst),
            .run     (en_q),
            .hit     (hit),
            .src_on  (cfg_q[i].src != '0),
            .wr      (wr_val),
            .wdata   (reg_wdata[CW-1:0]),
            .cnt     (cnt_arr[i]),
            .sat     (sat_v[i]),
            .stepped (step_v[i])
        );

        assign irq_v[i]   = irq_fire(cfg_q[i].mode, sat_v[i], step_v[i]);
        assign mode_on[i] = cfg_q[i].mode != IRQ_OFF;
    end

    assign irq = |irq_v;

    always_comb begin
        rd_mux = '0;
        if (reg_addr == A_CTRL) begin
            rd_mux = DW'(en_q);
        end
        for (int i = 0; i < NUM_C; i++) begin
            if (reg_addr == cfg_addr(i)) begin
                rd_mux = DW'(cfg_q[i]);
            end
            if (reg_addr == val_addr(i)) begin
                rd_mux = DW'(cnt_arr[i]);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            reg_rdata <= '0;
        end else if (rd_go) begin
            reg_rdata <= rd_mux;
        end else begin
            reg_rdata <= '0;
        end
    end

    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (rst)
        (mode_on == '0) |-> !irq); // R8
    AST_IRQ_SAT: assert property (@(posedge clk) disable iff (rst)
        (cfg_q[0].mode == IRQ_SAT && cnt_arr[0] == '1) |-> irq); // R8
    AST_READ_CTRL: assert property (@(posedge clk) disable iff (rst)
        (rd_go && reg_addr == A_CTRL) |=> (reg_rdata == DW'($past(en_q)))); // R6

endmodule

// File: tb/cache_evt_ctr_tb.sv
module cache_evt_ctr_tb;
    localparam int CLK_PERIOD = 10;

    localparam logic [4:0] A_CTRL = 5'h00;
    localparam logic [4:0] A_CFG1 = 5'h04;
    localparam logic [4:0] A_CFG0 = 5'h08;
    localparam logic [4:0] A_VAL1 = 5'h0C;
    localparam logic [4:0] A_VAL0 = 5'h10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_sel = 1'b0;
    logic        reg_wr = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [14:0] evt_in = '0;
    logic [31:0] reg_rdata;
    logic        irq;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    cache_evt_ctr u_dut (
        .clk       (clk),
        .rst       (rst),
        .reg_sel   (reg_sel),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .evt_in    (evt_in),
        .reg_rdata (reg_rdata),
        .irq       (irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_sel = 1'b1; reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_sel = 1'b0; reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_sel = 1'b1; reg_wr = 1'b0; reg_addr = a;
        @(negedge clk);
        reg_sel = 1'b0;
        d = reg_rdata;
    endtask

    task automatic pulse(input logic [14:0] m);
        @(negedge clk);
        evt_in = m;
        @(negedge clk);
        evt_in = '0;
    endtask

    task automatic report();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            report();
        end
    end

    initial begin
        logic [31:0] d;
        logic [31:0] other;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        rd_reg(A_CTRL, d); chk("R1 ctrl", d, 0);
        rd_reg(A_CFG0, d); chk("R1 cfg0", d, 0);
        rd_reg(A_CFG1, d); chk("R1 cfg1", d, 0);
        rd_reg(A_VAL0, d); chk("R1 val0", d, 0);
        rd_reg(A_VAL1, d); chk("R1 val1", d, 0);
        chk("R1 irq", 32'(irq), 0);

        // R5: field layout and readback
        wr_reg(A_CFG0, 32'hFFFF_FF2D);
        rd_reg(A_CFG0, d); chk("R5 cfg0 fields", d, 32'h2D);
        wr_reg(A_CFG1, 32'h0000_0036);
        rd_reg(A_CFG1, d); chk("R5 cfg1 fields", d, 32'h36);
        wr_reg(A_CFG0, 0);
        wr_reg(A_CFG1, 0);
        wr_reg(A_CTRL, 1);
        rd_reg(A_CTRL, d); chk("R3 ctrl enable readback", d, 1);

        // R4/R9: sweep every source code on both counters
        for (int i = 0; i < 2; i++) begin
            for (int c = 1; c < 16; c++) begin
                wr_reg(i == 0 ? A_CFG1 : A_CFG0, 0);
                wr_reg(i == 0 ? A_VAL0 : A_VAL1, 0);
                rd_reg(i == 0 ? A_VAL1 : A_VAL0, other);
                wr_reg(i == 0 ? A_CFG0 : A_CFG1, 32'(c << 2));
                for (int k = 0; k < 15; k++) pulse(15'(1 << k));
                for (int n = 0; n < c; n++) pulse(15'(1 << (c - 1)));
                rd_reg(i == 0 ? A_VAL0 : A_VAL1, d);
                chk($sformatf("R4 R9 ctr%0d code%0d", i, c), d, 32'(c + 1));
                rd_reg(i == 0 ? A_VAL1 : A_VAL0, d);
                chk($sformatf("R4 idle ctr code%0d", c), d, other);
            end
        end

        // R4: code 0 ignores everything
        wr_reg(A_CFG1, 0);
        wr_reg(A_VAL1, 32'h55);
        pulse(15'h7FFF); pulse(15'h7FFF);
        rd_reg(A_VAL1, d); chk("R4 code0 ignores", d, 32'h55);

        // R3: freeze while disabled
        wr_reg(A_CFG0, 32'(3 << 2));
        wr_reg(A_VAL0, 32'h20);
        wr_reg(A_CTRL, 0);
        pulse(15'h4); pulse(15'h4); pulse(15'h4);
        rd_reg(A_VAL0, d); chk("R3 frozen", d, 32'h20);
        wr_reg(A_CTRL, 1);
        pulse(15'h4);
        rd_reg(A_VAL0, d); chk("R3 resumes", d, 32'h21);

        // R7: write collides with counted event
        wr_reg(A_CFG0, 32'(1 << 2));
        @(negedge clk);
        reg_sel = 1'b1; reg_wr = 1'b1; reg_addr = A_VAL0; reg_wdata = 32'h100; evt_in = 15'h1;
        @(negedge clk);
        reg_sel = 1'b0; reg_wr = 1'b0; evt_in = '0;
        rd_reg(A_VAL0, d); chk("R7 write wins", d, 32'h100);

        // R6: read during increment returns pre-increment value one cycle later
        @(negedge clk);
        reg_sel = 1'b1; reg_wr = 1'b0; reg_addr = A_VAL0; evt_in = 15'h1;
        @(negedge clk);
        reg_sel = 1'b0; evt_in = '0;
        chk("R6 read latency", reg_rdata, 32'h100);
        rd_reg(A_VAL0, d); chk("R6 later read", d, 32'h101);

        // R2: saturation
        wr_reg(A_VAL0, 32'hFFFF_FFFD);
        for (int n = 0; n < 5; n++) pulse(15'h1);
        rd_reg(A_VAL0, d); chk("R2 saturates", d, 32'hFFFF_FFFF);
        chk("R8 mode00 quiet at max", 32'(irq), 0);
        wr_reg(A_CFG0, 32'h05);
        chk("R8 mode01 high at max", 32'(irq), 1);
        pulse(15'h1);
        rd_reg(A_VAL0, d); chk("R2 sticks", d, 32'hFFFF_FFFF);
        wr_reg(A_VAL0, 0);
        chk("R8 mode01 low after clear", 32'(irq), 0);
        rd_reg(A_VAL0, d); chk("R2 cleared by write", d, 0);

        // R8: mode 10 pulse after an increment
        wr_reg(A_CFG0, 32'(1 << 2));
        wr_reg(A_CFG1, 32'h0A);
        @(negedge clk);
        evt_in = 15'h2;
        @(negedge clk);
        evt_in = '0;
        chk("R8 mode10 pulse", 32'(irq), 1);
        @(negedge clk);
        chk("R8 mode10 one cycle", 32'(irq), 0);

        done = 1'b1;
        report();
    end
endmodule